// File: doc/BRIEF.md
# Two-wire serial memory slave

This block is the slave side of a two-wire serial bus that fronts a byte-addressable nonvolatile array. SCL and SDA are oversampled on the system clock. The block finds start and stop conditions and decodes a device address byte. It then accepts a two-byte array address and serves sector programs, current-address reads, random reads and sequential reads. It owns the internal address counter. SDA is modelled as open drain: the block only ever pulls the line low through `sda_oe`.

Program data goes into a one-sector staging buffer. A stop condition commits the staged bytes to the array and starts a simulated program cycle that lasts `BUSY_CYC` clock cycles. During that cycle the block ignores the bus, so the host can poll for completion by sending address bytes until one is acknowledged. A protection unit elsewhere decides whether a commit is allowed, and reports this on `wr_permit`, which the block samples at the stop.

Top module: `tws_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. When no program cycle is running, a start at any point, including part way through a byte, returns the block to receiving a device address. A stop returns it to idle with SDA released.
- R2: A device address byte is acknowledged only when its bits 7..4 are 1010 and its bits 3..1 equal `dev_sel`. Bit 0 selects the operation (1 read, 0 program). On a mismatch there is no acknowledge, and later bytes are ignored until the next start.
- R3: Two address bytes follow a program header, upper byte first. The array address is the upper byte's bits 5..0 followed by the lower byte. Bits 7..6 of the upper byte, and any address bits at or above `ADDR_W`, are ignored.
- R4: Every data byte of a program is acknowledged. The byte index, which is the address's low `SECT_W` bits, advances and wraps inside the sector while the sector bits stay fixed. A later byte that lands on an index already written replaces the earlier one.
- R5: A stop after at least one data byte, with `wr_permit` high, writes the staged bytes into the array and starts a program cycle of `BUSY_CYC` clocks.
- R6: During a program cycle SDA stays released and nothing on the bus is acted on. A device address sent then gets no acknowledge, and one sent after the cycle ends is acknowledged.
- R7: With `wr_permit` low at the stop, the data bytes are still acknowledged, but the array is unchanged and no program cycle starts.
- R8: A program header and address followed by a stop, with no data byte, only loads the address counter. No program cycle follows, and the next current-address read returns the byte at the loaded address.
- R9: The address counter holds the last byte accessed plus one. After a program it points to the index after the last byte programmed, wrapped inside that sector. A current-address read returns the byte at the counter.
- R10: When the master acknowledges a read byte, the next byte follows. Read addresses wrap from the last array address to 0.
- R11: When the master does not acknowledge a read byte, the block stops transmitting and leaves SDA released until the next start.
- R12: A repeated start after the address bytes, followed by a read header, returns data starting at the address just sent.
- R13: Bits are sent and received MSB first. SDA output changes only while SCL is low. An acknowledge holds SDA low for the whole high phase of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| dev_sel | input | 3 | Select code the device address byte must match |
| wr_permit | input | 1 | High when the protection unit allows the pending commit |

## Verification
The hardest conditions to reach are those that depend on the array's history. Checking the address counter after a program that wraps inside a sector, or a read that wraps from the last array address to zero, needs the neighbouring locations to have been written earlier with known values. The bench therefore walks a table of program bursts chosen so that their sectors overlap: one burst wraps into bytes written by an earlier burst, one fills the top of the array, one fills its bottom, and one runs past a full sector. A shadow model in the bench predicts every byte. The program-cycle window is reached by polling straight after each stop, which shows one refused address and then an acknowledged one.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_WAIT
  } tws_state_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/tws_sync.sv
module tws_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw;
  assign raw = {sda_i, scl_i};

  // one three-stage line per bus wire: two sync flops plus one history flop
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [2:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 3'b111;
      else        q <= {q[1:0], raw[g]};
    end
  end

  logic scl_p, sda_p;
  assign scl_s = g_line[0].q[1];
  assign scl_p = g_line[0].q[2];
  assign sda_s = g_line[1].q[1];
  assign sda_p = g_line[1].q[2];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tws_mem.sv
module tws_mem #(
  parameter int ADDR_W   = 11,
  parameter int SECT_W   = 5,
  parameter int BUSY_CYC = 2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  input  logic                     buf_clr,
  input  logic                     buf_ld,
  input  logic [SECT_W-1:0]        ld_idx,
  input  logic [7:0]               ld_data,
  input  logic                     commit_req,
  input  logic [ADDR_W-SECT_W-1:0] sect,
  output logic                     busy
);
  localparam int SECT_BYTES = 1 << SECT_W;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int TW         = $clog2(BUSY_CYC + 1);

  logic [7:0]               arr  [DEPTH];
  logic [7:0]               pbuf [SECT_BYTES];
  logic [SECT_BYTES-1:0]    vld;
  logic [TW-1:0]            tmr;
  logic [SECT_W:0]          widx;
  logic [ADDR_W-SECT_W-1:0] wsect;
  logic                     pend, commit_go, wr_slot;

  assign pend      = |vld;
  assign commit_go = commit_req & pend & ~busy;
  assign wr_slot   = busy & ~widx[SECT_W] & vld[widx[SECT_W-1:0]];

  always_ff @(posedge clk) rd_data <= arr[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_slot) arr[{wsect, widx[SECT_W-1:0]}] <= pbuf[widx[SECT_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (buf_ld) pbuf[ld_idx] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      tmr   <= '0;
      widx  <= '0;
      wsect <= '0;
      vld   <= '0;
    end else if (busy) begin
      if (!widx[SECT_W]) widx <= widx + (SECT_W+1)'(1);
      if (tmr == '0) begin
        busy <= 1'b0;
        vld  <= '0;
      end else begin
        tmr <= tmr - TW'(1);
      end
    end else if (commit_go) begin
      busy  <= 1'b1;
      tmr   <= TW'(BUSY_CYC - 1);
      widx  <= '0;
      wsect <= sect;
    end else begin
      if (buf_clr) vld <= '0;
      if (buf_ld)  vld[ld_idx] <= 1'b1;
    end
  end

  // R8: a program cycle only begins when staged data exists
  p_commit_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pend));
endmodule

// File: rtl/tws_slave.sv
module tws_slave #(
  parameter int ADDR_W   = 11,
  parameter int SECT_W   = 5,
  parameter int BUSY_CYC = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] dev_sel,
  input  logic       wr_permit
);
  import tws_pkg::*;

  localparam int SECT_HI = ADDR_W - SECT_W;

  function automatic logic [ADDR_W-1:0] rd_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] pg_next(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:SECT_W], a[SECT_W-1:0] + SECT_W'(1)};
  endfunction

  function automatic logic dev_hit(input logic [6:0] b, input logic [2:0] sel);
    return (b[6:3] == DEV_TYPE) && (b[2:0] == sel);
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [5:0] hi, input logic [7:0] lo);
    return ADDR_W'({hi, lo});
  endfunction

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  tws_sync u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_s, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det
  );

  tws_state_t        st;
  logic [7:0]        sh, tx;
  logic [3:0]        bcnt;
  logic              ackph, acked, rd_mode, mack;
  logic [5:0]        ahi;
  logic [ADDR_W-1:0] cnt;
  logic [7:0]        rd_data;
  logic              busy;

  // named internal events
  logic rx_state, rx_done, rx_ack, buf_clr, buf_ld, commit_req;
  assign rx_state   = (st == ST_DEV) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_WDAT);
  assign rx_done    = rx_state && scl_fall && !ackph && (bcnt == 4'd8)
                      && !busy && !start_det && !stop_det;
  assign rx_ack     = (st == ST_DEV) ? dev_hit(sh[7:1], dev_sel) : 1'b1;
  assign buf_clr    = rx_done && (st == ST_DEV) && rx_ack && !sh[0];
  assign buf_ld     = rx_done && (st == ST_WDAT);
  assign commit_req = stop_det && (st == ST_WDAT) && wr_permit && !busy;

  tws_mem #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BUSY_CYC(BUSY_CYC)) u_mem (
    .clk, .rst_n,
    .rd_addr(cnt), .rd_data,
    .buf_clr, .buf_ld,
    .ld_idx(cnt[SECT_W-1:0]), .ld_data(sh),
    .commit_req,
    .sect(cnt[ADDR_W-1:SECT_W]),
    .busy
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sh <= '0; tx <= '0; bcnt <= '0;
      ackph <= 1'b0; acked <= 1'b0; rd_mode <= 1'b0; mack <= 1'b0;
      ahi <= '0; cnt <= '0; sda_oe <= 1'b0;
    end else if (busy) begin
      st <= ST_IDLE; ackph <= 1'b0; sda_oe <= 1'b0; bcnt <= '0;
    end else if (start_det) begin
      st <= ST_DEV; ackph <= 1'b0; sda_oe <= 1'b0; bcnt <= '0;
    end else if (stop_det) begin
      st <= ST_IDLE; ackph <= 1'b0; sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise && !ackph && bcnt < 4'd8) begin
            sh   <= {sh[6:0], sda_s};
            bcnt <= bcnt + 4'd1;
          end
          if (rx_done) begin
            ackph  <= 1'b1;
            acked  <= rx_ack;
            sda_oe <= rx_ack;
            case (st)
              ST_DEV:  rd_mode <= sh[0];
              ST_AHI:  ahi <= sh[5:0];
              ST_ALO:  cnt <= join_addr(ahi, sh);
              default: cnt <= pg_next(cnt);
            endcase
          end
          if (scl_fall && ackph) begin
            ackph  <= 1'b0;
            sda_oe <= 1'b0;
            bcnt   <= '0;
            if (!acked) st <= ST_WAIT;
            else begin
              case (st)
                ST_DEV: begin
                  if (rd_mode) begin
                    st     <= ST_RDAT;
                    tx     <= rd_data;
                    sda_oe <= ~rd_data[7];
                  end else st <= ST_AHI;
                end
                ST_AHI:  st <= ST_ALO;
                default: st <= ST_WDAT;
              endcase
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            if (bcnt < 4'd8) bcnt <= bcnt + 4'd1;
            else if (bcnt == 4'd8) begin
              mack <= ~sda_s;
              bcnt <= 4'd9;
            end
          end
          if (scl_fall) begin
            if (bcnt == 4'd8) begin
              sda_oe <= 1'b0;
              cnt    <= rd_next(cnt);
            end else if (bcnt == 4'd9) begin
              if (mack) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                bcnt   <= '0;
              end else st <= ST_WAIT;
            end else if (bcnt != 4'd0) begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R6: the line is left alone for the whole program cycle
  p_quiet_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R13: the drive only moves while the synchronised clock is low
  p_oe_scl_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R11: the master's acknowledge slot is never driven by the block
  p_mack_slot_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RDAT && bcnt == 4'd9) |-> !sda_oe);

  // R4: staging a data byte never moves the sector bits of the counter
  p_sector_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ld |=> (cnt[ADDR_W-1:SECT_W] == $past(cnt[ADDR_W-1:SECT_W])));

  // R2: a wrong type code yields a released ninth clock
  p_type_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && st == ST_DEV && sh[7:4] != DEV_TYPE) |=> !sda_oe);

  logic [SECT_HI-1:0] unused_chk;
  assign unused_chk = cnt[ADDR_W-1:SECT_W];
endmodule

// File: tb/tb_tws_slave.sv
module tb_tws_slave;
  localparam int AW   = 11;
  localparam int SW   = 5;
  localparam int BUSY = 600;
  localparam int HP   = 20;
  localparam int NV   = 6;
  // {start address, byte count}
  localparam logic [19:0] VEC [NV] = '{
    {14'h0040, 6'd4}, {14'h005E, 6'd5}, {14'h07FC, 6'd4},
    {14'h0000, 6'd3}, {14'h0100, 6'd34}, {14'h0323, 6'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wr_permit = 1'b1;
  logic [2:0] dev_sel = 3'b101;
  wire  sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  tws_slave #(.ADDR_W(AW), .SECT_W(SW), .BUSY_CYC(BUSY)) dut (
    .clk, .rst_n, .scl_i(scl_m), .sda_i(sda_line), .sda_oe, .dev_sel, .wr_permit
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] shadow [1 << AW];
  logic       sv     [1 << AW];
  logic [7:0] rbuf   [40];

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart;
    if (!scl_m) begin sda_m = 1'b1; cyc(HP); scl_m = 1'b1; cyc(HP); end
    else begin sda_m = 1'b1; cyc(HP); end
    sda_m = 1'b0; cyc(HP); scl_m = 1'b0; cyc(4);
  endtask

  task automatic bstop;
    sda_m = 1'b0; cyc(HP); scl_m = 1'b1; cyc(HP); sda_m = 1'b1; cyc(2 * HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; cyc(HP); scl_m = 1'b1; cyc(HP); scl_m = 1'b0; cyc(4);
    end
    sda_m = 1'b1; cyc(HP); scl_m = 1'b1;
    cyc(HP / 4); a1 = sda_line;
    cyc(HP / 2); a2 = sda_line;
    cyc(HP - HP / 4 - HP / 2); scl_m = 1'b0; cyc(4);
    ack = !a1 && !a2;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cyc(HP); scl_m = 1'b1; cyc(HP / 2); b = {b[6:0], sda_line};
      cyc(HP / 2); scl_m = 1'b0; cyc(4);
    end
    sda_m = !mack; cyc(HP); scl_m = 1'b1; cyc(HP); scl_m = 1'b0; cyc(4); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dbyte(input logic rd);
    return {4'b1010, dev_sel, rd};
  endfunction

  task automatic header(input int addr, input logic [7:0] hi_extra, output logic ok);
    logic a0, a1, a2;
    send_byte(dbyte(1'b0), a0);
    send_byte(8'(addr >> 8) | hi_extra, a1);
    send_byte(8'(addr), a2);
    ok = a0 && a1 && a2;
  endtask

  task automatic rd_bytes(input int n);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
  endtask

  task automatic rand_read(input int addr, input logic [7:0] hi_extra, input int n, output logic ok);
    logic h, a;
    bstart; header(addr, hi_extra, h);
    bstart; send_byte(dbyte(1'b1), a);
    rd_bytes(n); bstop;
    ok = h && a;
  endtask

  task automatic cur_read(input int n, output logic ok);
    bstart; send_byte(dbyte(1'b1), ok); rd_bytes(n); bstop;
  endtask

  task automatic poll_once(output logic ack);
    bstart; send_byte(dbyte(1'b0), ack); bstop;
  endtask

  task automatic prog(input int addr, input int n, input int e, output logic ok);
    logic h, a;
    int base, idx;
    bstart; header(addr, 8'h00, h);
    ok = h;
    base = addr & ((1 << AW) - 1) & ~((1 << SW) - 1);
    for (int k = 0; k < n; k++) begin
      send_byte(8'(e * 40 + k * 7 + 3), a);
      ok = ok && a;
      if (wr_permit) begin
        idx = base | ((addr + k) & ((1 << SW) - 1));
        shadow[idx] = 8'(e * 40 + k * 7 + 3);
        sv[idx] = 1'b1;
      end
    end
    bstop;
  endtask

  initial begin
    cyc(190000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ok, ack;
    int a, nx, last, base, rl, polls;
    for (int i = 0; i < (1 << AW); i++) sv[i] = 1'b0;

    cyc(10);
    chk(sda_oe == 1'b0, "R1 reset releases SDA", int'(sda_oe), 0);
    rst_n = 1'b1; cyc(10);

    // R2: wrong select and wrong type, then bytes without a start are ignored
    bstart; send_byte({4'b1010, 3'b011, 1'b0}, ack);
    chk(!ack, "R2 select mismatch nack", int'(ack), 0);
    send_byte(8'h00, ack);
    chk(!ack, "R2 ignored until start", int'(ack), 0);
    bstop;
    bstart; send_byte({4'b1011, dev_sel, 1'b0}, ack);
    chk(!ack, "R2 type mismatch nack", int'(ack), 0);
    bstop;

    // table of program bursts, each followed by polling and readback
    for (int e = 0; e < NV; e++) begin
      a = int'(VEC[e][19:6]);
      prog(a, int'(VEC[e][5:0]), e, ok);
      chk(ok, "R4 every program byte acknowledged", int'(ok), 1);
      poll_once(ack);
      chk(!ack, "R6 no ack while program cycle runs", int'(ack), 0);
      polls = 0;
      while (!ack && polls < 20) begin poll_once(ack); polls++; end
      chk(ack, "R5 ack returns after program cycle", int'(ack), 1);
      // R9: counter sits after the last programmed byte, wrapped in the sector
      base = a & ((1 << AW) - 1) & ~((1 << SW) - 1);
      last = base | ((a + int'(VEC[e][5:0]) - 1) & ((1 << SW) - 1));
      nx   = base | ((last + 1) & ((1 << SW) - 1));
      if (sv[nx]) begin
        cur_read(1, ok);
        chk(ok && rbuf[0] == shadow[nx], "R9 current read after program", int'(rbuf[0]), int'(shadow[nx]));
      end
      rl = (VEC[e][5:0] > 6'd32) ? 32 : int'(VEC[e][5:0]);
      rand_read(a, 8'h00, rl, ok);
      chk(ok, "R12 random read header acked", int'(ok), 1);
      for (int i = 0; i < rl; i++) begin
        nx = (a + i) & ((1 << AW) - 1);
        if (sv[nx])
          chk(rbuf[i] == shadow[nx], "R5 R10 readback data", int'(rbuf[i]), int'(shadow[nx]));
      end
    end

    // R10: read wraps from the last array address to 0
    rand_read(2046, 8'h00, 4, ok);
    chk(rbuf[1] == shadow[2047], "R10 last array byte", int'(rbuf[1]), int'(shadow[2047]));
    chk(rbuf[2] == shadow[0], "R10 wrap to address 0", int'(rbuf[2]), int'(shadow[0]));
    chk(rbuf[3] == shadow[1], "R10 after wrap", int'(rbuf[3]), int'(shadow[1]));

    // R3: unused upper address bits are ignored
    rand_read(16'h0040, 8'hF8, 1, ok);
    chk(ok && rbuf[0] == shadow[16'h0040], "R3 upper bits ignored", int'(rbuf[0]), int'(shadow[16'h0040]));

    // R8: header then stop only loads the counter
    bstart; header(16'h0100, 8'h00, ok); bstop;
    cur_read(1, ok);
    chk(ok, "R8 no program cycle after empty header", int'(ok), 1);
    chk(rbuf[0] == shadow[16'h0100], "R8 counter loaded", int'(rbuf[0]), int'(shadow[16'h0100]));

    // R1 R12: start part way through the header leaves the counter unchanged
    bstart; send_byte(dbyte(1'b0), ack); send_byte(8'h00, ack);
    sda_m = 1'b1; cyc(HP); scl_m = 1'b1; cyc(HP); scl_m = 1'b0; cyc(4);
    bstart; send_byte(dbyte(1'b1), ack);
    rd_bytes(1); bstop;
    chk(ack && rbuf[0] == shadow[16'h0101], "R1 start aborts header", int'(rbuf[0]), int'(shadow[16'h0101]));

    // R7: denied commit leaves the array alone and starts no cycle
    wr_permit = 1'b0;
    prog(16'h0323, 1, 7, ok);
    chk(ok, "R7 denied data still acked", int'(ok), 1);
    poll_once(ack);
    chk(ack, "R7 no program cycle when denied", int'(ack), 1);
    wr_permit = 1'b1;
    rand_read(16'h0323, 8'h00, 1, ok);
    chk(rbuf[0] == shadow[16'h0323], "R7 array unchanged", int'(rbuf[0]), int'(shadow[16'h0323]));

    // R11 R13: after a master nack the line stays released under extra clocks
    bstart; send_byte(dbyte(1'b1), ack); recv_byte(1'b0, rbuf[0]);
    ok = 1'b1;
    for (int i = 0; i < 9; i++) begin
      cyc(HP); scl_m = 1'b1; cyc(HP / 2); if (sda_oe) ok = 1'b0;
      cyc(HP / 2); scl_m = 1'b0; cyc(4); if (sda_oe) ok = 1'b0;
    end
    chk(ok, "R11 R13 released after master nack", int'(ok), 1);
    bstop;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule